// File: doc/BRIEF.md
# Soft-Connect Capacitor Sequencer

This controller places a bank of internal test capacitors in parallel with a powered circuit under test without a current spike, and later takes them out the same way. It produces a digital gate-drive level (a ramp code that an analog stage turns into a gate voltage), an enable per capacitor switch, and a drive for the relay that removes the bleed resistor from the bank. Its inputs are a debounced trigger level, a charge-current comparator flag, over-voltage and reverse-voltage flags, and the capacitor selection.

Holding the trigger ramps the gate code up one step per programmable interval. The ramp pauses while charge current is flagged. Releasing the trigger ramps the code down at a faster interval, drops the relay, then turns every switch on for a programmable bleed time. Any voltage fault cuts the gate code and the relay in the same cycle. After a fault the controller waits for the flags to clear and the trigger to be let go before it bleeds the bank and returns to rest. The lock output freezes the capacitor selection logic while a sequence is in progress.

Top module: `cap_blend_ctrl`

## Requirements
- R1: `phase_o` encodes rest=0, ramp-up=1, connected=2, ramp-down=3, bleed=4, fault=5. At rest with no fault, `relay_o`=0, `gate_code_o`=0 and every bit of `gate_en_o` is 1.
- R2: While `ovv_i` or `rev_i` is 1, `alert_o` is 1 and a trigger press never engages the relay or starts a ramp.
- R3: A trigger press at rest with no fault gives `phase_o`=1 at the next edge, with `relay_o`=1, `gate_code_o`=0 and `gate_en_o` equal to `sel_mask_i` as sampled at that edge. Later changes of `sel_mask_i` do not alter `gate_en_o` until the next press.
- R4: In ramp-up the code rises by one every `up_div_i` cycles (0 acts as 1), counted from entry. While `ovc_i` is 1 the code holds its value, and it resumes after the flag falls.
- R5: At the edge where the code reaches its all-ones maximum, `phase_o` becomes 2 and stays there while the trigger is held.
- R6: After release, the code falls by one every D cycles, where D is `dn_div_i` (0 acts as 1) clamped to at most `up_div_i`−1 (at least 1). One cycle after the code is 0, `phase_o`=4 with `relay_o`=0 and all gates on, for `bleed_len_i` cycles (0 acts as 1). Then `phase_o`=0.
- R7: Releasing the trigger during ramp-up gives `phase_o`=3 at the next edge, with the code it held at that edge.
- R8: A trigger held or pressed during ramp-down or bleed does not alter the sequence. A new ramp starts only from rest.
- R9: In the cycle a voltage fault appears, `gate_code_o`=0, `relay_o`=0 and `gate_en_o`=0, whatever the trigger. At the next edge `phase_o`=5.
- R10: `lock_o` is 1 in every phase except rest, and 0 at rest.
- R11: The fault phase is left only when both fault flags are 0 and the trigger is 0. It then goes to bleed (phase 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Clean trigger level, 1 = held |
| ovc_i | input | 1 | Charge current above limit |
| ovv_i | input | 1 | Input voltage too high |
| rev_i | input | 1 | Input voltage reversed |
| sel_mask_i | input | NCAP | Capacitors chosen for the test |
| up_div_i | input | PRE_W | Cycles per up-ramp step |
| dn_div_i | input | PRE_W | Cycles per down-ramp step (clamped) |
| bleed_len_i | input | BLD_W | Bleed phase length in cycles |
| gate_code_o | output | CODE_W | Gate drive level code |
| gate_en_o | output | NCAP | Per-capacitor switch enable |
| relay_o | output | 1 | Relay drive, 1 = bleed resistor removed |
| phase_o | output | 3 | Sequencer phase code |
| alert_o | output | 1 | Voltage fault indication |
| lock_o | output | 1 | Freeze for the selection logic |

## Verification
The step properties assume that the interval inputs and the bleed length stay constant for the whole of a sequence, and that the fault and current flags are already synchronous to `clk`. The stimulus changes the intervals only at rest. It drives every input 5 ns after a rising edge, and raises fault flags only from states where the expected reaction can be computed. The sweep covers all interval values from 0 to 3 for both ramps and bleed lengths from 0 to 2, including the cases where the clamp decides the down-ramp interval.

// File: rtl/cap_blend_pkg.sv
package cap_blend_pkg;

  typedef enum logic [2:0] {
    PH_REST = 3'd0,
    PH_UP   = 3'd1,
    PH_CONN = 3'd2,
    PH_DN   = 3'd3,
    PH_BLD  = 3'd4,
    PH_FLT  = 3'd5
  } phase_e;

endpackage

// File: rtl/blend_pacer.sv
// Interval counter: emits one tick every len_i cycles while run is high.
module blend_pacer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         run,
  input  logic [W-1:0] len_i,
  output logic         tick_o
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d, len_eff;
  logic         cnt_en;

  always_comb begin
    len_eff = (len_i == '0) ? ONE : len_i;
    tick_o  = run && (cnt_q == (len_eff - ONE));
    cnt_en  = restart || run;
    if (restart || tick_o) cnt_d = '0;
    else                   cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/blend_ramp.sv
// Gate level code: clear has priority, then increment, then decrement.
module blend_ramp #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic              dec,
  output logic [CODE_W-1:0] code_o,
  output logic              near_top_o,
  output logic              at_zero_o
);

  localparam logic [CODE_W-1:0] TOP = '1;
  localparam logic [CODE_W-1:0] ONE = {{(CODE_W-1){1'b0}}, 1'b1};

  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;

  always_comb begin
    code_d  = code_q;
    code_en = clr || inc || dec;
    if (clr)                         code_d = '0;
    else if (inc && (code_q != TOP)) code_d = code_q + ONE;
    else if (dec && (code_q != '0))  code_d = code_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  assign code_o     = code_q;
  assign near_top_o = (code_q == (TOP - ONE));
  assign at_zero_o  = (code_q == '0);

endmodule

// File: rtl/blend_fsm.sv
// Phase sequencing, selection capture and ramp step decisions.
module blend_fsm
  import cap_blend_pkg::*;
#(
  parameter int NCAP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_i,
  input  logic            flt_i,
  input  logic            ovc_i,
  input  logic            near_top_i,
  input  logic            at_zero_i,
  input  logic            up_tick_i,
  input  logic            dn_tick_i,
  input  logic            bld_tick_i,
  input  logic [NCAP-1:0] sel_mask_i,
  output phase_e          phase_o,
  output logic [NCAP-1:0] mask_o,
  output logic            restart_o,
  output logic            inc_o,
  output logic            dec_o,
  output logic            clr_o,
  output logic            up_run_o,
  output logic            dn_run_o,
  output logic            bld_run_o
);

  phase_e          st_q, st_d;
  logic [NCAP-1:0] mask_q, mask_d;
  logic            mask_en;

  always_comb begin
    st_d    = st_q;
    mask_d  = mask_q;
    mask_en = 1'b0;
    inc_o   = 1'b0;
    dec_o   = 1'b0;
    clr_o   = 1'b0;
    unique case (st_q)
      PH_REST: begin
        if (trig_i) begin
          st_d    = PH_UP;
          mask_d  = sel_mask_i;
          mask_en = 1'b1;
        end
      end
      PH_UP: begin
        if (!trig_i) begin
          st_d = PH_DN;
        end else if (up_tick_i && !ovc_i) begin
          inc_o = 1'b1;
          if (near_top_i) st_d = PH_CONN;
        end
      end
      PH_CONN: begin
        if (!trig_i) st_d = PH_DN;
      end
      PH_DN: begin
        if (at_zero_i)      st_d  = PH_BLD;
        else if (dn_tick_i) dec_o = 1'b1;
      end
      PH_BLD: begin
        if (bld_tick_i) st_d = PH_REST;
      end
      PH_FLT: begin
        if (!trig_i) st_d = PH_BLD;
      end
      default: st_d = PH_REST;
    endcase
    if (flt_i) begin
      st_d    = PH_FLT;
      mask_en = 1'b0;
      inc_o   = 1'b0;
      dec_o   = 1'b0;
      clr_o   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PH_REST;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign restart_o = (st_d != st_q);
  assign up_run_o  = (st_q == PH_UP);
  assign dn_run_o  = (st_q == PH_DN);
  assign bld_run_o = (st_q == PH_BLD);
  assign phase_o   = st_q;
  assign mask_o    = mask_q;

endmodule

// File: rtl/cap_blend_ctrl.sv
// Top: pacing counters, ramp, sequencer and fault gating of the drives.
module cap_blend_ctrl
  import cap_blend_pkg::*;
#(
  parameter int NCAP   = 4,
  parameter int CODE_W = 8,
  parameter int PRE_W  = 16,
  parameter int BLD_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              ovc_i,
  input  logic              ovv_i,
  input  logic              rev_i,
  input  logic [NCAP-1:0]   sel_mask_i,
  input  logic [PRE_W-1:0]  up_div_i,
  input  logic [PRE_W-1:0]  dn_div_i,
  input  logic [BLD_W-1:0]  bleed_len_i,
  output logic [CODE_W-1:0] gate_code_o,
  output logic [NCAP-1:0]   gate_en_o,
  output logic              relay_o,
  output logic [2:0]        phase_o,
  output logic              alert_o,
  output logic              lock_o
);

  localparam logic [PRE_W-1:0] P_ONE = {{(PRE_W-1){1'b0}}, 1'b1};

  // reset: asserted asynchronously, removed two edges after rst_n rises
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic flt;
  assign flt = ovv_i | rev_i;

  // down interval: never longer than the up interval minus one
  logic [PRE_W-1:0] up_eff, dn_eff, dn_use;
  always_comb begin
    up_eff = (up_div_i == '0) ? P_ONE : up_div_i;
    dn_eff = (dn_div_i == '0) ? P_ONE : dn_div_i;
    if (dn_eff < up_eff)   dn_use = dn_eff;
    else if (up_eff > P_ONE) dn_use = up_eff - P_ONE;
    else                   dn_use = P_ONE;
  end

  phase_e            st;
  logic [NCAP-1:0]   mask;
  logic              restart, inc, dec, clr;
  logic              up_run, dn_run, bld_run;
  logic              up_tick, dn_tick, bld_tick;
  logic [CODE_W-1:0] code;
  logic              near_top, at_zero;

  blend_pacer #(.W(PRE_W)) u_up_pace (
    .clk(clk), .rst_n(rst_int_n), .restart(restart), .run(up_run),
    .len_i(up_eff), .tick_o(up_tick)
  );

  blend_pacer #(.W(PRE_W)) u_dn_pace (
    .clk(clk), .rst_n(rst_int_n), .restart(restart), .run(dn_run),
    .len_i(dn_use), .tick_o(dn_tick)
  );

  blend_pacer #(.W(BLD_W)) u_bld_pace (
    .clk(clk), .rst_n(rst_int_n), .restart(restart), .run(bld_run),
    .len_i(bleed_len_i), .tick_o(bld_tick)
  );

  blend_ramp #(.CODE_W(CODE_W)) u_ramp (
    .clk(clk), .rst_n(rst_int_n), .clr(clr), .inc(inc), .dec(dec),
    .code_o(code), .near_top_o(near_top), .at_zero_o(at_zero)
  );

  blend_fsm #(.NCAP(NCAP)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .trig_i(trig_i), .flt_i(flt),
    .ovc_i(ovc_i), .near_top_i(near_top), .at_zero_i(at_zero),
    .up_tick_i(up_tick), .dn_tick_i(dn_tick), .bld_tick_i(bld_tick),
    .sel_mask_i(sel_mask_i), .phase_o(st), .mask_o(mask),
    .restart_o(restart), .inc_o(inc), .dec_o(dec), .clr_o(clr),
    .up_run_o(up_run), .dn_run_o(dn_run), .bld_run_o(bld_run)
  );

  logic linked, bleeding;
  assign linked   = (st == PH_UP) || (st == PH_CONN) || (st == PH_DN);
  assign bleeding = (st == PH_REST) || (st == PH_BLD);

  // fault cuts the gate level and relay combinationally, ahead of the state
  assign gate_code_o = flt ? '0 : code;
  assign relay_o     = linked && !flt;

  for (genvar i = 0; i < NCAP; i++) begin : g_gate
    always_comb begin
      if (flt)         gate_en_o[i] = 1'b0;
      else if (linked) gate_en_o[i] = mask[i];
      else             gate_en_o[i] = bleeding;
    end
  end

  assign phase_o = st;
  assign alert_o = flt || (st == PH_FLT);
  assign lock_o  = (st != PH_REST);

endmodule

// File: rtl/cap_blend_chk.sv
module cap_blend_chk #(
  parameter int NCAP   = 4,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_i,
  input logic              ovc_i,
  input logic              ovv_i,
  input logic              rev_i,
  input logic [CODE_W-1:0] gate_code_o,
  input logic [NCAP-1:0]   gate_en_o,
  input logic              relay_o,
  input logic [2:0]        phase_o,
  input logic              alert_o,
  input logic              lock_o
);

  localparam logic [CODE_W-1:0] C_ONE = {{(CODE_W-1){1'b0}}, 1'b1};

  logic flt;
  assign flt = ovv_i | rev_i;

  assert_rest_bleed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd0 && !flt) |-> (gate_en_o == '1 && !relay_o && gate_code_o == '0));

  assert_alert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flt |-> alert_o);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd1 && ovc_i && trig_i && !flt) |=> (flt || gate_code_o == $past(gate_code_o)));

  assert_up_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd1 && !flt) |=>
      (flt || gate_code_o == $past(gate_code_o) || gate_code_o == $past(gate_code_o) + C_ONE));

  assert_conn_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd2 && !flt) |-> (gate_code_o == '1));

  assert_dn_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd3 && !flt) |=>
      (flt || gate_code_o == $past(gate_code_o) || gate_code_o == $past(gate_code_o) - C_ONE));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_o == 3'd3 || phase_o == 3'd4) && !flt) |=>
      (phase_o == 3'd3 || phase_o == 3'd4 || phase_o == 3'd0 || phase_o == 3'd5));

  assert_fault_cut_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flt |-> (gate_code_o == '0 && !relay_o && gate_en_o == '0));

  assert_fault_enter_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flt |=> (phase_o == 3'd5));

  assert_relay_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    relay_o |-> lock_o);

  assert_fault_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd5 && (trig_i || flt)) |=> (phase_o == 3'd5));

endmodule

bind cap_blend_ctrl cap_blend_chk #(.NCAP(NCAP), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .ovc_i(ovc_i), .ovv_i(ovv_i),
  .rev_i(rev_i), .gate_code_o(gate_code_o), .gate_en_o(gate_en_o),
  .relay_o(relay_o), .phase_o(phase_o), .alert_o(alert_o), .lock_o(lock_o)
);

// File: tb/sim_cap_blend_ctrl.sv
module sim_cap_blend_ctrl;

  localparam int NC  = 4;
  localparam int CW  = 3;
  localparam int PW  = 4;
  localparam int BW  = 4;
  localparam int TOP = (1 << CW) - 1;

  logic          clk, rst_n, trig, ovc, ovv, rev;
  logic [NC-1:0] sel;
  logic [PW-1:0] up_div, dn_div;
  logic [BW-1:0] bld;
  logic [CW-1:0] code;
  logic [NC-1:0] gen;
  logic          relay, alert, lock;
  logic [2:0]    phase;

  int vectors = 0;
  int misses  = 0;

  cap_blend_ctrl #(.NCAP(NC), .CODE_W(CW), .PRE_W(PW), .BLD_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .ovc_i(ovc), .ovv_i(ovv),
    .rev_i(rev), .sel_mask_i(sel), .up_div_i(up_div), .dn_div_i(dn_div),
    .bleed_len_i(bld), .gate_code_o(code), .gate_en_o(gen), .relay_o(relay),
    .phase_o(phase), .alert_o(alert), .lock_o(lock)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic expect_eq(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #5;
  endtask

  task automatic drain();
    for (int n = 0; n < 200; n++) begin
      if (phase == 3'd0) break;
      cyc();
    end
    expect_eq("R6 back at rest", int'(phase), 0);
  endtask

  // one full press-hold-release sequence with computed timing
  task automatic sweep_one(input int ud, input int dd, input int bl, input int mask,
                           input bit hold_in_dn);
    int ue, de, le;
    ue = (ud == 0) ? 1 : ud;
    de = (dd == 0) ? 1 : dd;
    if (de >= ue) de = (ue > 1) ? ue - 1 : 1;
    le = (bl == 0) ? 1 : bl;
    up_div = PW'(ud); dn_div = PW'(dd); bld = BW'(bl);
    sel = NC'(mask);
    trig = 1'b1;
    cyc();
    expect_eq("R3 phase up", int'(phase), 1);
    expect_eq("R3 relay", int'(relay), 1);
    expect_eq("R3 gate mask", int'(gen), mask);
    expect_eq("R10 lock in ramp", int'(lock), 1);
    sel = ~NC'(mask);
    for (int k = 0; k < TOP * ue; k++) begin
      expect_eq("R4 up code", int'(code), k / ue);
      expect_eq("R4 up phase", int'(phase), 1);
      cyc();
    end
    expect_eq("R5 connected", int'(phase), 2);
    expect_eq("R5 top code", int'(code), TOP);
    expect_eq("R3 mask kept", int'(gen), mask);
    cyc();
    expect_eq("R5 stays connected", int'(phase), 2);
    trig = 1'b0;
    cyc();
    if (hold_in_dn) trig = 1'b1;
    for (int k = 0; k <= TOP * de; k++) begin
      expect_eq("R6 down phase", int'(phase), 3);
      expect_eq("R6 down code", int'(code), TOP - k / de);
      cyc();
    end
    for (int j = 0; j < le; j++) begin
      expect_eq("R6 bleed phase", int'(phase), 4);
      expect_eq("R6 bleed relay", int'(relay), 0);
      expect_eq("R6 bleed gates", int'(gen), (1 << NC) - 1);
      expect_eq("R10 lock in bleed", int'(lock), 1);
      if (j == le - 1) trig = 1'b0;
      cyc();
    end
    expect_eq("R8 R6 rest after bleed", int'(phase), 0);
    expect_eq("R1 rest gates", int'(gen), (1 << NC) - 1);
    expect_eq("R10 unlock at rest", int'(lock), 0);
    cyc();
    expect_eq("R1 rest stays", int'(phase), 0);
  endtask

  initial begin
    #(20 * 150000);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rst_n = 1'b0; trig = 1'b0; ovc = 1'b0; ovv = 1'b0; rev = 1'b0;
    sel = '0; up_div = PW'(1); dn_div = PW'(1); bld = BW'(1);
    cyc(); cyc();
    expect_eq("R1 reset phase", int'(phase), 0);
    expect_eq("R1 reset relay", int'(relay), 0);
    expect_eq("R1 reset code", int'(code), 0);
    expect_eq("R1 reset gates", int'(gen), (1 << NC) - 1);
    expect_eq("R10 reset lock", int'(lock), 0);
    rst_n = 1'b1;
    cyc(); cyc(); cyc();

    // sweep of all small interval and bleed settings
    for (int ud = 0; ud < 4; ud++)
      for (int dd = 0; dd < 4; dd++)
        for (int bl = 0; bl < 3; bl++)
          sweep_one(ud, dd, bl, (ud * 5 + dd * 3 + bl + 1) % 16, bl == 2);

    // R7: release part way up
    up_div = PW'(2); dn_div = PW'(1); bld = BW'(1); sel = 4'b0101;
    trig = 1'b1;
    cyc();
    for (int k = 0; k < 6; k++) cyc();
    expect_eq("R7 code before release", int'(code), 3);
    trig = 1'b0;
    cyc();
    expect_eq("R7 reversed phase", int'(phase), 3);
    expect_eq("R7 reversed code", int'(code), 3);
    cyc();
    expect_eq("R7 falling code", int'(code), 2);
    drain();

    // R4: current flag holds the ramp
    up_div = PW'(1);
    trig = 1'b1;
    cyc(); cyc(); cyc();
    expect_eq("R4 code before hold", int'(code), 2);
    ovc = 1'b1;
    for (int k = 0; k < 5; k++) begin
      cyc();
      expect_eq("R4 held code", int'(code), 2);
      expect_eq("R4 held phase", int'(phase), 1);
    end
    ovc = 1'b0;
    cyc();
    expect_eq("R4 resumed code", int'(code), 3);
    trig = 1'b0;
    cyc();
    drain();

    // R9 and R11: fault while connected, trigger still held
    sel = 4'b1010;
    trig = 1'b1;
    cyc();
    for (int k = 0; k < TOP; k++) cyc();
    expect_eq("R5 connected before fault", int'(phase), 2);
    ovv = 1'b1;
    #1;
    expect_eq("R9 code cut", int'(code), 0);
    expect_eq("R9 relay cut", int'(relay), 0);
    expect_eq("R9 gates cut", int'(gen), 0);
    expect_eq("R2 alert on", int'(alert), 1);
    cyc();
    expect_eq("R9 fault phase", int'(phase), 5);
    expect_eq("R10 lock in fault", int'(lock), 1);
    ovv = 1'b0;
    cyc(); cyc();
    expect_eq("R11 held trigger keeps fault", int'(phase), 5);
    expect_eq("R11 relay off in fault", int'(relay), 0);
    trig = 1'b0;
    cyc();
    expect_eq("R11 exit to bleed", int'(phase), 4);
    drain();

    // R2: press ignored under reverse voltage
    rev = 1'b1; trig = 1'b1;
    #1;
    expect_eq("R2 alert reverse", int'(alert), 1);
    for (int k = 0; k < 4; k++) begin
      cyc();
      expect_eq("R2 no relay", int'(relay), 0);
      expect_eq("R2 no ramp", int'(code), 0);
    end
    expect_eq("R2 fault phase", int'(phase), 5);
    rev = 1'b0;
    cyc();
    expect_eq("R11 flags clear but trigger held", int'(phase), 5);
    trig = 1'b0;
    cyc();
    expect_eq("R11 bleed after fault", int'(phase), 4);
    drain();
    expect_eq("R2 alert cleared", int'(alert), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule